// File: doc/BRIEF.md
# Three-Wire Serial Configuration Loader

This block takes configuration words for a dual-channel frequency synthesizer from a slow three-wire serial port. The three wires are a shift clock, a data line and a load strobe. All three are asynchronous to the system clock, so the block first synchronises them and then detects their edges. Each word is 22 bits long: a 20-bit payload followed by a 2-bit routing code. When the load strobe rises, the payload is stored in one of four configuration registers: the IF reference register, the RF reference register, the IF divider register or the RF divider register.

The stored registers are decoded into named control fields. These are the reference division ratio, the phase-detector polarity, the pump-current range, the pump tri-state, the two monitor-output selects, the swallow and main counts, the prescaler modulus select and the powerdown request. A two-bit power state for each channel combines the tri-state bit of its reference register with the powerdown bit of its divider register.

Top module: `cfgload_top`

## Requirements
- R1: On each rising edge of the synchronised shift clock, the synchronised data bit enters the shift register, and the first bit sent becomes the most significant. When more than 22 bits are sent, only the last 22 are kept.
- R2: The routing code is the last two bits sent. The earlier of the two is the code MSB. Code 0 selects the IF reference register, 1 the RF reference register, 2 the IF divider register and 3 the RF divider register.
- R3: On a rising edge of the load strobe, the 20 bits sent before the routing code are copied into the addressed register. The decoded outputs show the new value no more than 4 system clock cycles after the strobe input rises.
- R4: A load changes only the addressed register. Holding the strobe high, shifting while it is high, or lowering it loads nothing.
- R5: Reference register field positions, with bit 1 the last payload bit sent: bits 1-15 hold the ratio (bit 1 is the ratio LSB), bit 16 is the detector polarity, bit 17 the pump-current range, bit 18 the pump tri-state, bit 19 the lock-monitor enable and bit 20 the divider-monitor select.
- R6: Divider register field positions: bits 1-7 hold the swallow count and bits 8-18 the main count (bit 8 is its LSB). Bit 19 is the prescaler select and bit 20 is powerdown. The IF swallow output uses only bits 1-4, so bits 5-7 have no effect on the IF channel.
- R7: Each channel's power state is 0 (active) when tri-state and powerdown are both 0. It is 1 (pump tri-state only) when only tri-state is 1, 2 (synchronous powerdown) when only powerdown is 1, and 3 (asynchronous powerdown) when both are 1.
- R8: A synchronous active-low reset clears all four registers. Every output then reads zero and both power states read active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sclk_in | input | 1 | Serial shift clock, asynchronous |
| sdata_in | input | 1 | Serial data, asynchronous |
| le_in | input | 1 | Load strobe, asynchronous |
| if_ref_ratio | output | 15 | IF reference division ratio |
| if_det_pol | output | 1 | IF detector polarity |
| if_cp_hi | output | 1 | IF pump-current range high |
| if_cp_hiz | output | 1 | IF pump tri-state |
| if_lock_en | output | 1 | IF lock-monitor enable |
| if_div_mon | output | 1 | IF divider-monitor select |
| rf_ref_ratio | output | 15 | RF reference division ratio |
| rf_det_pol | output | 1 | RF detector polarity |
| rf_cp_hi | output | 1 | RF pump-current range high |
| rf_cp_hiz | output | 1 | RF pump tri-state |
| rf_lock_en | output | 1 | RF lock-monitor enable |
| rf_div_mon | output | 1 | RF divider-monitor select |
| if_swallow | output | 4 | IF swallow count |
| if_main | output | 11 | IF main count |
| if_presc_hi | output | 1 | IF prescaler select |
| if_pwdn | output | 1 | IF powerdown request |
| rf_swallow | output | 7 | RF swallow count |
| rf_main | output | 11 | RF main count |
| rf_presc_hi | output | 1 | RF prescaler select |
| rf_pwdn | output | 1 | RF powerdown request |
| if_pwr_state | output | 2 | IF power state |
| rf_pwr_state | output | 2 | RF power state |

## Verification
The assertions check on every cycle that each detected shift-clock edge moves the register by exactly one bit, that load pulses last one cycle, that a load copies the payload into the addressed register while every other register holds, and that an asynchronous-powerdown state always comes with both of its source bits set. The bench scenarios show the parts that span whole words. These are the field placement after full serial transfers, the discarding of surplus leading bits, and the absence of a load while the strobe stays high. They also show that the IF swallow output ignores its upper bits and that the four power states follow from two different registers.

// File: rtl/cfgload_pkg.sv
// Package: shared types and register-slot numbers for the serial configuration loader.
// Assumes the slot numbers match the routing code values.
package cfgload_pkg;

    typedef enum logic [1:0] {
        PWR_ACTIVE   = 2'd0,
        PWR_CP_HIZ   = 2'd1,
        PWR_SYNC_PD  = 2'd2,
        PWR_ASYNC_PD = 2'd3
    } pwr_state_e;

    localparam int unsigned SLOT_IF_REF = 0;
    localparam int unsigned SLOT_RF_REF = 1;
    localparam int unsigned SLOT_IF_DIV = 2;
    localparam int unsigned SLOT_RF_DIV = 3;

    // Combines the pump tri-state and powerdown bits into a power state.
    function automatic pwr_state_e pwr_decode(input logic hiz, input logic pwdn);
        case ({pwdn, hiz})
            2'b00:   return PWR_ACTIVE;
            2'b01:   return PWR_CP_HIZ;
            2'b10:   return PWR_SYNC_PD;
            default: return PWR_ASYNC_PD;
        endcase
    endfunction

endpackage

// File: rtl/cfgload_sync.sv
// Module: multi-stage synchroniser for a group of asynchronous single-bit inputs.
// Assumes each input is held for longer than STAGES+1 system clock cycles.
module cfgload_sync #(
    parameter int unsigned W      = 3,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    logic [W-1:0] pipe [STAGES];

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            // Each stage registers the previous one (the first stage registers the pins).
            always_ff @(posedge clk) begin
                if (!rst_n)      pipe[g] <= '0;
                else if (g == 0) pipe[g] <= async_in;
                else             pipe[g] <= pipe[(g == 0) ? 0 : g - 1];
            end
        end
    endgenerate

    assign sync_out = pipe[STAGES-1];
endmodule

// File: rtl/cfgload_shift.sv
// Module: edge detection on the synchronised shift clock and load strobe, plus the
// serial shift register. Assumes the data bit is stable around each shift-clock rise.
module cfgload_shift #(
    parameter int unsigned PAYLOAD_W = 20,
    parameter int unsigned ADDR_W    = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sclk_s,
    input  logic                 sdata_s,
    input  logic                 le_s,
    output logic [PAYLOAD_W-1:0] payload,
    output logic [ADDR_W-1:0]    code,
    output logic                 load
);
    localparam int unsigned SR_W = PAYLOAD_W + ADDR_W;

    logic [SR_W-1:0] sr;
    logic            sclk_q;
    logic            le_q;
    logic            shift_en;

    // Keeps the previous synchronised levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_q <= 1'b0;
            le_q   <= 1'b0;
        end else begin
            sclk_q <= sclk_s;
            le_q   <= le_s;
        end
    end

    assign shift_en = sclk_s & ~sclk_q;
    assign load     = le_s & ~le_q;

    // Shifts one bit in at each shift-clock rise; the first bit sent ends up at the MSB.
    always_ff @(posedge clk) begin
        if (!rst_n)        sr <= '0;
        else if (shift_en) sr <= {sr[SR_W-2:0], sdata_s};
    end

    assign payload = sr[SR_W-1:ADDR_W];
    assign code    = sr[ADDR_W-1:0];

    // R1
    shift_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> (sr == {$past(sr[SR_W-2:0]), $past(sdata_s)}));

    // R1
    shift_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> $stable(sr));

    // R3
    load_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> !load);
endmodule

// File: rtl/cfgload_bank.sv
// Module: bank of configuration registers, one per routing code value.
// Assumes load is a single-cycle pulse and code/payload are valid with it.
module cfgload_bank #(
    parameter int unsigned PAYLOAD_W = 20,
    parameter int unsigned ADDR_W    = 2
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              load,
    input  logic [ADDR_W-1:0]                 code,
    input  logic [PAYLOAD_W-1:0]              payload,
    output logic [(1<<ADDR_W)-1:0][PAYLOAD_W-1:0] regs
);
    localparam int unsigned SLOTS = 1 << ADDR_W;

    generate
        for (genvar s = 0; s < SLOTS; s++) begin : g_slot
            logic hit;
            assign hit = load && (code == ADDR_W'(s));

            // Captures the payload when this slot is addressed by a load.
            always_ff @(posedge clk) begin
                if (!rst_n)   regs[s] <= '0;
                else if (hit) regs[s] <= payload;
            end

            // R3
            slot_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (load && (code == ADDR_W'(s))) |=> (regs[s] == $past(payload)));

            // R4
            slot_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
                !(load && (code == ADDR_W'(s))) |=> $stable(regs[s]));
        end
    endgenerate
endmodule

// File: rtl/cfgload_top.sv
// Module: three-wire serial configuration loader. It synchronises the pins, shifts the
// word in, routes the payload to one of four registers and decodes the control fields.
// Assumes RATIO_W + 5 == SWALLOW_W + MAIN_W + 2 (both formats fill the payload).
module cfgload_top
    import cfgload_pkg::*;
#(
    parameter int unsigned RATIO_W      = 15,
    parameter int unsigned SWALLOW_W    = 7,
    parameter int unsigned IF_SWALLOW_W = 4,
    parameter int unsigned MAIN_W       = 11,
    parameter int unsigned SYNC_STAGES  = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    sclk_in,
    input  logic                    sdata_in,
    input  logic                    le_in,
    output logic [RATIO_W-1:0]      if_ref_ratio,
    output logic                    if_det_pol,
    output logic                    if_cp_hi,
    output logic                    if_cp_hiz,
    output logic                    if_lock_en,
    output logic                    if_div_mon,
    output logic [RATIO_W-1:0]      rf_ref_ratio,
    output logic                    rf_det_pol,
    output logic                    rf_cp_hi,
    output logic                    rf_cp_hiz,
    output logic                    rf_lock_en,
    output logic                    rf_div_mon,
    output logic [IF_SWALLOW_W-1:0] if_swallow,
    output logic [MAIN_W-1:0]       if_main,
    output logic                    if_presc_hi,
    output logic                    if_pwdn,
    output logic [SWALLOW_W-1:0]    rf_swallow,
    output logic [MAIN_W-1:0]       rf_main,
    output logic                    rf_presc_hi,
    output logic                    rf_pwdn,
    output logic [1:0]              if_pwr_state,
    output logic [1:0]              rf_pwr_state
);
    localparam int unsigned ADDR_W    = 2;
    localparam int unsigned PAYLOAD_W = RATIO_W + 5;
    localparam int unsigned POL_B     = RATIO_W;
    localparam int unsigned CUR_B     = RATIO_W + 1;
    localparam int unsigned HIZ_B     = RATIO_W + 2;
    localparam int unsigned LD_B      = RATIO_W + 3;
    localparam int unsigned MON_B     = RATIO_W + 4;
    localparam int unsigned MAIN_LO   = SWALLOW_W;
    localparam int unsigned PRESC_B   = SWALLOW_W + MAIN_W;
    localparam int unsigned PWDN_B    = SWALLOW_W + MAIN_W + 1;

    logic [2:0]                                  pins_s;
    logic [PAYLOAD_W-1:0]                        payload;
    logic [ADDR_W-1:0]                           code;
    logic                                        load;
    logic [(1<<ADDR_W)-1:0][PAYLOAD_W-1:0]       regs;
    logic [PAYLOAD_W-1:0] if_ref, rf_ref, if_div, rf_div;

    cfgload_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .async_in({le_in, sdata_in, sclk_in}),
        .sync_out(pins_s)
    );

    cfgload_shift #(.PAYLOAD_W(PAYLOAD_W), .ADDR_W(ADDR_W)) u_shift (
        .clk(clk), .rst_n(rst_n),
        .sclk_s(pins_s[0]), .sdata_s(pins_s[1]), .le_s(pins_s[2]),
        .payload(payload), .code(code), .load(load)
    );

    cfgload_bank #(.PAYLOAD_W(PAYLOAD_W), .ADDR_W(ADDR_W)) u_bank (
        .clk(clk), .rst_n(rst_n),
        .load(load), .code(code), .payload(payload),
        .regs(regs)
    );

    assign if_ref = regs[SLOT_IF_REF];
    assign rf_ref = regs[SLOT_RF_REF];
    assign if_div = regs[SLOT_IF_DIV];
    assign rf_div = regs[SLOT_RF_DIV];

    // Reference register decode (R5).
    assign if_ref_ratio = if_ref[RATIO_W-1:0];
    assign if_det_pol   = if_ref[POL_B];
    assign if_cp_hi     = if_ref[CUR_B];
    assign if_cp_hiz    = if_ref[HIZ_B];
    assign if_lock_en   = if_ref[LD_B];
    assign if_div_mon   = if_ref[MON_B];
    assign rf_ref_ratio = rf_ref[RATIO_W-1:0];
    assign rf_det_pol   = rf_ref[POL_B];
    assign rf_cp_hi     = rf_ref[CUR_B];
    assign rf_cp_hiz    = rf_ref[HIZ_B];
    assign rf_lock_en   = rf_ref[LD_B];
    assign rf_div_mon   = rf_ref[MON_B];

    // Divider register decode (R6); the IF swallow count keeps only its low bits.
    assign if_swallow  = if_div[IF_SWALLOW_W-1:0];
    assign if_main     = if_div[MAIN_LO +: MAIN_W];
    assign if_presc_hi = if_div[PRESC_B];
    assign if_pwdn     = if_div[PWDN_B];
    assign rf_swallow  = rf_div[SWALLOW_W-1:0];
    assign rf_main     = rf_div[MAIN_LO +: MAIN_W];
    assign rf_presc_hi = rf_div[PRESC_B];
    assign rf_pwdn     = rf_div[PWDN_B];

    // Power state from the reference tri-state bit and the divider powerdown bit (R7).
    assign if_pwr_state = pwr_decode(if_ref[HIZ_B], if_div[PWDN_B]);
    assign rf_pwr_state = pwr_decode(rf_ref[HIZ_B], rf_div[PWDN_B]);

    // R7
    rf_async_pd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_pwr_state == 2'd3) |-> (rf_pwdn && rf_cp_hiz));

    // R7
    if_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (if_pwr_state == 2'd0) |-> (!if_pwdn && !if_cp_hiz));
endmodule

// File: tb/tb_cfgload_top.sv
module tb_cfgload_top;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk_in = 1'b0, sdata_in = 1'b0, le_in = 1'b0;

    logic [14:0] if_ref_ratio, rf_ref_ratio;
    logic if_det_pol, if_cp_hi, if_cp_hiz, if_lock_en, if_div_mon;
    logic rf_det_pol, rf_cp_hi, rf_cp_hiz, rf_lock_en, rf_div_mon;
    logic [3:0]  if_swallow;
    logic [10:0] if_main, rf_main;
    logic [6:0]  rf_swallow;
    logic if_presc_hi, if_pwdn, rf_presc_hi, rf_pwdn;
    logic [1:0] if_pwr_state, rf_pwr_state;

    int checks = 0;
    int failures = 0;
    bit done = 0;
    logic [19:0] m [4];

    always #(CLK_PERIOD/2) clk = ~clk;

    cfgload_top dut (
        .clk(clk), .rst_n(rst_n), .sclk_in(sclk_in), .sdata_in(sdata_in), .le_in(le_in),
        .if_ref_ratio(if_ref_ratio), .if_det_pol(if_det_pol), .if_cp_hi(if_cp_hi),
        .if_cp_hiz(if_cp_hiz), .if_lock_en(if_lock_en), .if_div_mon(if_div_mon),
        .rf_ref_ratio(rf_ref_ratio), .rf_det_pol(rf_det_pol), .rf_cp_hi(rf_cp_hi),
        .rf_cp_hiz(rf_cp_hiz), .rf_lock_en(rf_lock_en), .rf_div_mon(rf_div_mon),
        .if_swallow(if_swallow), .if_main(if_main), .if_presc_hi(if_presc_hi), .if_pwdn(if_pwdn),
        .rf_swallow(rf_swallow), .rf_main(rf_main), .rf_presc_hi(rf_presc_hi), .rf_pwdn(rf_pwdn),
        .if_pwr_state(if_pwr_state), .rf_pwr_state(rf_pwr_state)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int pwr_exp(input logic hiz, input logic pd);
        return {30'd0, pd, hiz};
    endfunction

    // Compares every output with the model of the four registers.
    task automatic check_all(input string req);
        @(negedge clk);
        chk(req, "if_ref_ratio", int'(if_ref_ratio), int'(m[0][14:0]));
        chk(req, "if_det_pol",   int'(if_det_pol),   int'(m[0][15]));
        chk(req, "if_cp_hi",     int'(if_cp_hi),     int'(m[0][16]));
        chk(req, "if_cp_hiz",    int'(if_cp_hiz),    int'(m[0][17]));
        chk(req, "if_lock_en",   int'(if_lock_en),   int'(m[0][18]));
        chk(req, "if_div_mon",   int'(if_div_mon),   int'(m[0][19]));
        chk(req, "rf_ref_ratio", int'(rf_ref_ratio), int'(m[1][14:0]));
        chk(req, "rf_det_pol",   int'(rf_det_pol),   int'(m[1][15]));
        chk(req, "rf_cp_hi",     int'(rf_cp_hi),     int'(m[1][16]));
        chk(req, "rf_cp_hiz",    int'(rf_cp_hiz),    int'(m[1][17]));
        chk(req, "rf_lock_en",   int'(rf_lock_en),   int'(m[1][18]));
        chk(req, "rf_div_mon",   int'(rf_div_mon),   int'(m[1][19]));
        chk(req, "if_swallow",   int'(if_swallow),   int'(m[2][3:0]));
        chk(req, "if_main",      int'(if_main),      int'(m[2][17:7]));
        chk(req, "if_presc_hi",  int'(if_presc_hi),  int'(m[2][18]));
        chk(req, "if_pwdn",      int'(if_pwdn),      int'(m[2][19]));
        chk(req, "rf_swallow",   int'(rf_swallow),   int'(m[3][6:0]));
        chk(req, "rf_main",      int'(rf_main),      int'(m[3][17:7]));
        chk(req, "rf_presc_hi",  int'(rf_presc_hi),  int'(m[3][18]));
        chk(req, "rf_pwdn",      int'(rf_pwdn),      int'(m[3][19]));
        chk(req, "if_pwr_state", int'(if_pwr_state), pwr_exp(m[0][17], m[2][19]));
        chk(req, "rf_pwr_state", int'(rf_pwr_state), pwr_exp(m[1][17], m[3][19]));
    endtask

    task automatic send_bit(input logic b);
        @(negedge clk); sdata_in = b;
        repeat (HALF) @(negedge clk); sclk_in = 1'b1;
        repeat (HALF) @(negedge clk); sclk_in = 1'b0;
    endtask

    task automatic shift_word(input logic [19:0] pl, input logic [1:0] code);
        for (int i = 19; i >= 0; i--) send_bit(pl[i]);
        send_bit(code[1]);
        send_bit(code[0]);
    endtask

    task automatic pulse_le();
        repeat (HALF) @(negedge clk); le_in = 1'b1;
        repeat (HALF) @(negedge clk); le_in = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic write_word(input logic [19:0] pl, input logic [1:0] code);
        shift_word(pl, code);
        pulse_le();
        m[code] = pl;
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            finish_run();
        end
    end

    initial begin
        int unsigned seed;
        logic [19:0] pl;
        seed = $urandom(32'h5EED);
        for (int k = 0; k < 4; k++) m[k] = '0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        // R8: all registers clear after reset
        check_all("R8");

        // R2 R5 R6: one directed word per code value
        write_word(20'hA_5003, 2'd0); check_all("R2");
        write_word(20'h5_7FFF, 2'd1); check_all("R5");
        write_word(20'hC_0185, 2'd2); check_all("R6");
        write_word(20'hB_FF7F, 2'd3); check_all("R2");

        // R6: IF swallow bits 5-7 ignored
        write_word(20'h0_0070, 2'd2);
        @(negedge clk);
        chk("R6", "if_swallow upper bits ignored", int'(if_swallow), 0);
        check_all("R6");

        // R1: surplus leading bits are discarded
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
        write_word(20'h3_0404, 2'd1); check_all("R1");

        // R4: shifting while the strobe stays high, then lowering it, loads nothing
        shift_word(20'h1_2345, 2'd3);
        repeat (HALF) @(negedge clk); le_in = 1'b1;
        repeat (HALF) @(negedge clk);
        m[3] = 20'h1_2345;
        check_all("R3");
        shift_word(20'hF_0F0F, 2'd3);
        le_in = 1'b0;
        repeat (6) @(negedge clk);
        check_all("R4");

        // R7: all four power states on both channels
        for (int s = 0; s < 4; s++) begin
            write_word({2'b00, s[0], 17'h0_0064}, 2'd0);
            write_word({s[1], 19'h0_0308}, 2'd2);
            write_word({2'b01, s[0], 17'h1_00C8}, 2'd1);
            write_word({s[1], 19'h4_0A05}, 2'd3);
            @(negedge clk);
            chk("R7", "if_pwr_state", int'(if_pwr_state), s);
            chk("R7", "rf_pwr_state", int'(rf_pwr_state), s);
        end

        // R3 R4: random words to random codes
        for (int n = 0; n < 40; n++) begin
            pl = 20'($urandom);
            write_word(pl, 2'($urandom));
            check_all("R3");
        end

        // R8: reset again clears everything
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk); rst_n = 1'b1;
        for (int k = 0; k < 4; k++) m[k] = '0;
        check_all("R8");

        done = 1;
        finish_run();
    end
endmodule